// File: doc/BRIEF.md
# Event Timer Global Registers and Main Counter

This block holds the shared register set of a multi-channel event timer. It contains the free-running 64-bit main counter, the read-only capability words, the global configuration (a run bit and a legacy interrupt-routing bit) and the pending-interrupt status word. Software reaches all of it over a simple 32-bit register port that takes only whole-word accesses, with a 1 KB address window. The counter advances by one on every clock in which `tick_i` is high and the timer is running. It stops and keeps its value while the timer is halted.

The per-channel windows at the top of the address space are not stored here. They are decoded into a channel index and a word offset and handed to the channel logic, which returns its read data on `ch_rdata_i`. When the run bit changes, the block sends one-cycle arm or disarm pulses to the channels. Channels report events through `sts_set_i`. Software acknowledges an event by writing a one to its status bit, and the block then pulses `irq_drop_o` so that the channel can release its interrupt line.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset, the configuration, status and counter are zero, `rdata_o` is zero, and `arm_o`, `disarm_o` and `irq_drop_o` are all low.
- R2: The word at 0x000 reads 0x8086A001 with (N_CH-1) added at bits 12:8, so 0x8086A201 for three channels. The word at 0x004 reads PERIOD_FS. Writes to either word leave both unchanged.
- R3: At 0x010, bit 0 is the run bit (`enable_o`) and bit 1 is the legacy-route bit (`legacy_o`). All other bits of that word read zero. The word at 0x014 always reads zero and ignores writes. Any other unmapped or misaligned address reads zero.
- R4: While running, the counter grows by one per cycle in which `tick_i` is high, with a carry from the low half into the high half. While halted it holds its value, whatever `tick_i` does.
- R5: Writing 0x0F0 or 0x0F4 replaces only the low or the high counter half, whether the timer is running or not. A write takes priority over a tick in the same cycle.
- R6: `misuse_o` is high during the request cycle of a counter write made while running, and low for a counter write made while halted.
- R7: A 0-to-1 change of the run bit gives a one-cycle `arm_o` pulse in the first cycle that `enable_o` is high. In that pulse, bit i is set exactly when `cmp_ones_i[i]` is 0.
- R8: A 1-to-0 change of the run bit gives a one-cycle all-ones `disarm_o` pulse. It also clears every pending status bit and pulses `irq_drop_o` with the bits that were pending.
- R9: The status word at 0x020 latches `sts_set_i` bits only while running. If an event and a clear land on the same bit in the same cycle, the event wins and no drop is signalled for that bit.
- R10: A write to 0x020 clears each pending bit that is written as one. In the next cycle, `irq_drop_o` pulses for exactly those bits.
- R11: An address from 0x100 to 0x3FF selects channel (addr-0x100)/0x20 at word offset addr[4:0]. `ch_req_o` and `ch_we_o` follow the request in the same cycle, and a read returns `ch_rdata_i`.
- R12: A channel index of N_CH or more raises no `ch_req_o` and reads zero.
- R13: `rdata_o` is loaded at the clock edge that ends a read request, with the value at that edge, and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Access is a write |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| tick_i | input | 1 | Counter tick enable |
| cmp_ones_i | input | N_CH | Channel comparator is all ones |
| sts_set_i | input | N_CH | Channel event strobes |
| ch_rdata_i | input | 32 | Read data from the selected channel |
| ch_req_o | output | 1 | Channel window access |
| ch_we_o | output | 1 | Channel window write |
| ch_idx_o | output | IDX_W | Selected channel |
| ch_off_o | output | 5 | Byte offset in the channel window |
| count_o | output | 64 | Main counter value |
| enable_o | output | 1 | Global run bit |
| legacy_o | output | 1 | Legacy routing bit |
| arm_o | output | N_CH | Arm pulses to channels |
| disarm_o | output | N_CH | Disarm pulses to channels |
| irq_drop_o | output | N_CH | Interrupt release pulses |
| misuse_o | output | 1 | Counter written while running |

## Verification
The bench targets these edges:

- **Carry between counter halves.** A design without the carry would leave the high word stuck after the low word rolls over.
- **Half-word counter writes.** A design that did not keep the other half would corrupt the unaddressed word.
- **Arm mask.** If the arm mask were not built from `cmp_ones_i`, channels whose comparator is all ones would be re-armed.
- **Status set and clear.** The bench clears status both selectively and while an event lands on the same bit. A wrong priority would lose that event or report a false drop.
- **Halting with status pending.** A wrong design would leave stale pending bits with no drop pulse.
- **Channel windows.** An access just past the last implemented channel must not strobe the channel bus and must read zero.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [2:0] {
    G_NONE,
    G_CAP_LO,
    G_CAP_HI,
    G_CFG_LO,
    G_CFG_HI,
    G_STS,
    G_CNT_LO,
    G_CNT_HI
  } gsel_e;

  localparam int unsigned ADDR_W    = 10;
  localparam int unsigned MAX_CH    = 24;  // windows that fit in 0x100..0x3FF
  localparam logic [31:0] CAP_BASE  = 32'h8086_A001;
  localparam int unsigned CNT_SHIFT = 8;
endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec #(
  parameter int unsigned N_CH  = 3,
  parameter int unsigned IDX_W = $clog2(N_CH)
) (
  input  logic [evt_pkg::ADDR_W-1:0] addr_i,
  output evt_pkg::gsel_e             gsel_o,
  output logic                       chan_hit_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [4:0]                 off_o
);
  import evt_pkg::*;

  logic       aligned;
  logic       win;
  logic [4:0] raw_idx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign win     = |addr_i[9:8];
  assign raw_idx = addr_i[9:5] - 5'd8;
  assign idx_o   = raw_idx[IDX_W-1:0];
  assign off_o   = addr_i[4:0];

  assign chan_hit_o = aligned && win && (raw_idx < 5'(N_CH));

  always_comb begin
    gsel_o = G_NONE;
    if (aligned && !win) begin
      unique case (addr_i[7:2])
        6'h00:   gsel_o = G_CAP_LO;
        6'h01:   gsel_o = G_CAP_HI;
        6'h04:   gsel_o = G_CFG_LO;
        6'h05:   gsel_o = G_CFG_HI;
        6'h08:   gsel_o = G_STS;
        6'h3C:   gsel_o = G_CNT_LO;
        6'h3D:   gsel_o = G_CNT_HI;
        default: gsel_o = G_NONE;
      endcase
    end
  end
endmodule

// File: rtl/evt_main_cnt.sv
module evt_main_cnt #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             misuse_o
);
  localparam int unsigned HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q <= {cnt_q[CNT_W-1:32], wdata_i};
    end else if (wr_hi_i) begin
      cnt_q <= {wdata_i[HI_W-1:0], cnt_q[31:0]};
    end else if (en_i && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign misuse_o = en_i && (wr_lo_i || wr_hi_i);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_lo_i && !wr_hi_i) |=> cnt_q == $past(cnt_q));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !wr_lo_i && !wr_hi_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_half_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> cnt_q[CNT_W-1:32] == $past(cnt_q[CNT_W-1:32]));
endmodule

// File: rtl/evt_chan_ctl.sv
module evt_chan_ctl #(
  parameter int unsigned N_CH = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_q_i,
  input  logic            en_d_i,
  input  logic [N_CH-1:0] cmp_ones_i,
  input  logic [N_CH-1:0] sts_set_i,
  input  logic            sts_wr_i,
  input  logic [N_CH-1:0] wdata_i,
  output logic [N_CH-1:0] arm_o,
  output logic [N_CH-1:0] disarm_o,
  output logic [N_CH-1:0] drop_o,
  output logic [N_CH-1:0] sts_o
);
  logic            rise, fall;
  logic [N_CH-1:0] sts_q, sts_d, set_eff, clr, drop_d;

  assign rise    = en_d_i && !en_q_i;
  assign fall    = !en_d_i && en_q_i;
  assign set_eff = sts_set_i & {N_CH{en_q_i}};
  assign clr     = sts_wr_i ? (wdata_i & sts_q) : '0;

  always_comb begin
    if (fall) begin
      sts_d  = '0;
      drop_d = sts_q;
    end else begin
      sts_d  = (sts_q & ~clr) | set_eff;
      drop_d = clr & ~set_eff;  // a fresh event beats the acknowledge
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q    <= '0;
      arm_o    <= '0;
      disarm_o <= '0;
      drop_o   <= '0;
    end else begin
      sts_q    <= sts_d;
      arm_o    <= rise ? ~cmp_ones_i : '0;
      disarm_o <= fall ? '1 : '0;
      drop_o   <= drop_d;
    end
  end

  assign sts_o = sts_q;

  p_arm_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|arm_o) |-> (en_q_i && !$past(en_q_i)));
  p_disarm_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|disarm_o) |-> (!en_q_i && $past(en_q_i)));
  p_drop_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|drop_o) |-> ((drop_o & ~$past(sts_q)) == '0));
  p_no_set_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q_i |=> ((sts_q & ~$past(sts_q)) == '0));
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs #(
  parameter int unsigned N_CH      = 3,   // 3..24
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
  localparam int unsigned IDX_W    = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [9:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_i,
  input  logic [N_CH-1:0]   cmp_ones_i,
  input  logic [N_CH-1:0]   sts_set_i,
  input  logic [31:0]       ch_rdata_i,
  output logic              ch_req_o,
  output logic              ch_we_o,
  output logic [IDX_W-1:0]  ch_idx_o,
  output logic [4:0]        ch_off_o,
  output logic [63:0]       count_o,
  output logic              enable_o,
  output logic              legacy_o,
  output logic [N_CH-1:0]   arm_o,
  output logic [N_CH-1:0]   disarm_o,
  output logic [N_CH-1:0]   irq_drop_o,
  output logic              misuse_o
);
  import evt_pkg::*;

  localparam logic [31:0] CAP_LO = CAP_BASE | (32'(N_CH - 1) << CNT_SHIFT);

  gsel_e           gsel;
  logic            chan_hit;
  logic            wr, rd;
  logic            en_q, leg_q, en_d;
  logic            cfg_wr;
  logic [N_CH-1:0] sts;
  logic [31:0]     rd_val, rdata_q;

  evt_addr_dec #(.N_CH(N_CH), .IDX_W(IDX_W)) u_dec (
    .addr_i     (addr_i),
    .gsel_o     (gsel),
    .chan_hit_o (chan_hit),
    .idx_o      (ch_idx_o),
    .off_o      (ch_off_o)
  );

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign ch_req_o = req_i && chan_hit;
  assign ch_we_o  = wr && chan_hit;
  assign cfg_wr   = wr && (gsel == G_CFG_LO);
  assign en_d     = cfg_wr ? wdata_i[0] : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
    end else if (cfg_wr) begin
      en_q  <= wdata_i[0];
      leg_q <= wdata_i[1];
    end
  end

  assign enable_o = en_q;
  assign legacy_o = leg_q;

  evt_main_cnt #(.CNT_W(64)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .tick_i   (tick_i),
    .wr_lo_i  (wr && (gsel == G_CNT_LO)),
    .wr_hi_i  (wr && (gsel == G_CNT_HI)),
    .wdata_i  (wdata_i),
    .cnt_o    (count_o),
    .misuse_o (misuse_o)
  );

  evt_chan_ctl #(.N_CH(N_CH)) u_chan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_q_i     (en_q),
    .en_d_i     (en_d),
    .cmp_ones_i (cmp_ones_i),
    .sts_set_i  (sts_set_i),
    .sts_wr_i   (wr && (gsel == G_STS)),
    .wdata_i    (wdata_i[N_CH-1:0]),
    .arm_o      (arm_o),
    .disarm_o   (disarm_o),
    .drop_o     (irq_drop_o),
    .sts_o      (sts)
  );

  always_comb begin
    rd_val = '0;
    if (chan_hit) begin
      rd_val = ch_rdata_i;
    end else begin
      unique case (gsel)
        G_CAP_LO: rd_val = CAP_LO;
        G_CAP_HI: rd_val = PERIOD_FS;
        G_CFG_LO: rd_val = {30'd0, leg_q, en_q};
        G_STS:    rd_val = 32'(sts);
        G_CNT_LO: rd_val = count_o[31:0];
        G_CNT_HI: rd_val = count_o[63:32];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  p_chan_range_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_req_o |-> (ch_idx_o < IDX_W'(N_CH)));
  p_oor_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && |addr_i[9:8] && !chan_hit) |=> rdata_o == '0);
  p_rdata_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: tb/evt_timer_regs_tb.sv
`timescale 1ns/1ps
module evt_timer_regs_tb;
  localparam int unsigned N = 3;
  localparam int unsigned N_VEC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0, ch_rdata = '0;
  logic [N-1:0] cmp_ones = '0, sts_set = '0;
  logic [31:0] rdata;
  logic        ch_req, ch_we, enable, legacy, misuse;
  logic [1:0]  ch_idx;
  logic [4:0]  ch_off;
  logic [63:0] count;
  logic [N-1:0] arm, disarm, drop;

  int checks = 0, errors = 0;
  logic        l_misuse, l_ch_req, l_ch_we;
  logic [1:0]  l_idx;
  logic [4:0]  l_off;
  logic [31:0] rv;

  always #2 clk = ~clk;

  evt_timer_regs #(.N_CH(N), .PERIOD_FS(32'd10_000_000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .cmp_ones_i(cmp_ones),
    .sts_set_i(sts_set), .ch_rdata_i(ch_rdata), .ch_req_o(ch_req),
    .ch_we_o(ch_we), .ch_idx_o(ch_idx), .ch_off_o(ch_off), .count_o(count),
    .enable_o(enable), .legacy_o(legacy), .arm_o(arm), .disarm_o(disarm),
    .irq_drop_o(drop), .misuse_o(misuse)
  );

  // {is_write, addr, write data or expected read data}
  localparam logic [42:0] VEC [N_VEC] = '{
    {1'b0, 10'h000, 32'h8086A201},  // R2
    {1'b0, 10'h004, 32'h00989680},  // R2
    {1'b1, 10'h000, 32'hFFFFFFFF},
    {1'b0, 10'h000, 32'h8086A201},  // R2 write ignored
    {1'b1, 10'h004, 32'h00000000},
    {1'b0, 10'h004, 32'h00989680},  // R2 write ignored
    {1'b1, 10'h014, 32'hFFFFFFFF},
    {1'b0, 10'h014, 32'h00000000},  // R3
    {1'b1, 10'h010, 32'hFFFFFFFE},
    {1'b0, 10'h010, 32'h00000002},  // R3 only legacy bit kept
    {1'b1, 10'h010, 32'h00000000},
    {1'b0, 10'h010, 32'h00000000},  // R3
    {1'b1, 10'h0F0, 32'h12345678},
    {1'b1, 10'h0F4, 32'h9ABCDEF0},
    {1'b0, 10'h0F0, 32'h12345678},  // R5
    {1'b0, 10'h0F4, 32'h9ABCDEF0},  // R5
    {1'b1, 10'h0F0, 32'h11111111},
    {1'b0, 10'h0F4, 32'h9ABCDEF0},  // R5 other half kept
    {1'b0, 10'h080, 32'h00000000},  // R3 unmapped
    {1'b0, 10'h012, 32'h00000000}   // R3 misaligned
  };

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [9:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    l_misuse = misuse; l_ch_req = ch_req; l_ch_we = ch_we;
    l_idx = ch_idx; l_off = ch_off;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r = rdata;
  endtask

  task automatic do_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", 64'(rdata), 0);
    chk("R1 count", count, 0);
    chk("R1 enable", 64'(enable), 0);
    chk("R1 pulses", 64'({arm, disarm, drop}), 0);
    rst_n = 1'b1;
    bus(1'b0, 10'h020, 0, rv); chk("R1 status", 64'(rv), 0);

    for (int i = 0; i < N_VEC; i++) begin
      bus(VEC[i][42], VEC[i][41:32], VEC[i][31:0], rv);
      if (!VEC[i][42]) chk($sformatf("vector %0d", i), 64'(rv), 64'(VEC[i][31:0]));
    end
    chk("R3 legacy low", 64'(legacy), 0);

    // R4 hold while halted
    do_ticks(5);
    chk("R4 hold", count, 64'h9ABCDEF0_11111111);

    // R7 arm mask
    cmp_ones = 3'b010;
    bus(1'b1, 10'h010, 32'h1, rv);
    chk("R7 arm", 64'(arm), 64'(3'b101));
    chk("R7 enable", 64'(enable), 1);
    @(negedge clk);
    chk("R7 arm pulse", 64'(arm), 0);

    // R4 counting, R13 read value
    do_ticks(7);
    chk("R4 count", count, 64'h9ABCDEF0_11111118);
    bus(1'b0, 10'h0F0, 0, rv); chk("R13 cnt read", 64'(rv), 64'h11111118);
    @(negedge clk); @(negedge clk);
    chk("R13 hold", 64'(rdata), 64'h11111118);

    // R6 misuse, R5 write while running, R4 carry
    bus(1'b1, 10'h0F0, 32'hFFFFFFFF, rv);
    chk("R6 misuse", 64'(l_misuse), 1);
    chk("R5 write running", count, 64'h9ABCDEF0_FFFFFFFF);
    do_ticks(1);
    chk("R4 carry", count, 64'h9ABCDEF1_00000000);

    // R9 set, R10 clear
    @(negedge clk); sts_set = 3'b111; @(negedge clk); sts_set = '0;
    bus(1'b0, 10'h020, 0, rv); chk("R9 status set", 64'(rv), 7);
    bus(1'b1, 10'h020, 32'h5, rv);
    chk("R10 drop", 64'(drop), 64'(3'b101));
    bus(1'b0, 10'h020, 0, rv); chk("R10 status", 64'(rv), 2);
    bus(1'b1, 10'h020, 32'h0, rv);
    chk("R10 zero write drop", 64'(drop), 0);
    bus(1'b0, 10'h020, 0, rv); chk("R10 zero write", 64'(rv), 2);
    sts_set = 3'b010;
    bus(1'b1, 10'h020, 32'h2, rv);
    sts_set = '0;
    chk("R9 set wins drop", 64'(drop), 0);
    bus(1'b0, 10'h020, 0, rv); chk("R9 set wins", 64'(rv), 2);

    // R8 halt
    bus(1'b1, 10'h010, 32'h0, rv);
    chk("R8 disarm", 64'(disarm), 64'(3'b111));
    chk("R8 drop", 64'(drop), 64'(3'b010));
    chk("R8 enable", 64'(enable), 0);
    bus(1'b0, 10'h020, 0, rv); chk("R8 status cleared", 64'(rv), 0);
    do_ticks(4);
    chk("R4 frozen", count, 64'h9ABCDEF1_00000000);
    @(negedge clk); sts_set = 3'b111; @(negedge clk); sts_set = '0;
    bus(1'b0, 10'h020, 0, rv); chk("R9 halted ignore", 64'(rv), 0);
    bus(1'b1, 10'h0F4, 32'h0, rv);
    chk("R6 no misuse halted", 64'(l_misuse), 0);
    bus(1'b0, 10'h0F4, 0, rv); chk("R5 hi write", 64'(rv), 0);

    // R7 all comparators all-ones
    cmp_ones = 3'b111;
    bus(1'b1, 10'h010, 32'h1, rv);
    chk("R7 no arm", 64'(arm), 0);
    bus(1'b1, 10'h010, 32'h0, rv);

    // R11 channel windows
    ch_rdata = 32'hCAFE0001;
    bus(1'b0, 10'h108, 0, rv);
    chk("R11 req", 64'(l_ch_req), 1);
    chk("R11 idx0", 64'(l_idx), 0);
    chk("R11 off", 64'(l_off), 8);
    chk("R11 rdata", 64'(rv), 64'hCAFE0001);
    bus(1'b1, 10'h154, 32'h1, rv);
    chk("R11 we", 64'(l_ch_we), 1);
    chk("R11 idx2", 64'(l_idx), 2);
    chk("R11 off hi", 64'(l_off), 5'h14);

    // R12 out of range
    bus(1'b0, 10'h160, 0, rv);
    chk("R12 no req", 64'(l_ch_req), 0);
    chk("R12 zero", 64'(rv), 0);
    bus(1'b0, 10'h3FC, 0, rv);
    chk("R12 top zero", 64'(rv), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule